// File: doc/BRIEF.md
# Serial Control Port for a Host Microcontroller

This block is the slave side of a small serial link through which a host microcontroller configures a codec and polls it. The host raises an enable line, toggles a bit clock and moves data on a single shared data line whose direction the block controls. Two type-select lines, which must settle before enable rises, choose one of four transfer kinds: a short extended-settings byte that can drive general-purpose output pins, a 16-bit internal-settings write, a stream of 16-bit allocation and scale-factor words pushed into a small buffer for the codec to consume, and a 16-bit status read.

Every unit is moved least significant bit first within each byte. A 16-bit unit travels as two bytes with the high byte first, and enable stays high across both bytes. All pins are oversampled in the system clock domain through a synchronizer, so the host bit clock is seen as a rising-edge event rather than used as a clock. Buffer words are stored exactly as sent. Allocation nibbles keep their bit-count-minus-one coding, and scale factors keep their two leading zero pad bits. The codec drains the buffer through a show-ahead pop port. The status word carries a ready-to-receive flag, which the block inserts and which is high while the buffer has room.

Top module: `ctlport_top`

## Requirements
- R1: After reset the data line is released (`sdo_oe_o` = 0), `gpo_o` = 0, `cfg_o` = `CFG_RESET` (default 0) and the buffer is empty (`buf_valid_o` = 0).
- R2: Type code 2'b00 selects extended settings. Eight bits are sent in the order D0, D1, D2, D3, A0, A1, A2, A3. When the address A3..A0 is 0, D3..D0 are copied to `gpo_o[3:0]` after the eighth bit.
- R3: An extended-settings byte whose address is not 0 leaves `gpo_o` unchanged.
- R4: Type code 2'b10 writes internal settings. The 16-bit unit arrives high byte first, each byte least significant bit first, and is loaded into `cfg_o` after the sixteenth bit.
- R5: If enable falls before a unit is complete, nothing is written: `cfg_o`, `gpo_o` and the buffer keep their contents.
- R6: Type code 2'b01 pushes each completed 16-bit unit into the buffer. Several units may follow one another within a single enable window.
- R7: The buffer is first-in first-out. `buf_data_o` shows the oldest word while `buf_valid_o` is high. A pop while the buffer is empty is ignored.
- R8: A unit completed while the buffer is full, with no pop in the same cycle, is dropped. The ready flag, which is status bit 13, reads 0 while the buffer is full and 1 otherwise.
- R9: Type code 2'b11 reads status. `sdo_oe_o` is high during the read. The bits leave in the order status bit 8 up to bit 15, then bit 0 up to bit 7, and each new bit appears after a rising bit-clock edge. The word is captured when enable rises, so later changes of `status_i` do not alter it.
- R10: Within `SYNC`+1 clock cycles after enable falls, `sdo_oe_o` is 0.
- R11: When a unit completes in the same cycle as a pop of a full buffer, both take effect and the new word is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Host transfer enable |
| sck_i | input | 1 | Host bit clock |
| sel_i | input | 2 | Transfer type select |
| sdi_i | input | 1 | Data line, host to block |
| sdo_o | output | 1 | Data line, block to host |
| sdo_oe_o | output | 1 | Output enable for the data line |
| status_i | input | 16 | Codec status word (bit 13 is replaced by ready) |
| gpo_o | output | 4 | General-purpose outputs from extended settings |
| cfg_o | output | 16 | Internal settings register |
| buf_data_o | output | 16 | Oldest buffered allocation/scale-factor word |
| buf_valid_o | output | 1 | Buffer holds at least one word |
| buf_pop_i | input | 1 | Codec consumes the oldest word |

## Verification
A buffer push, caused by the last bit of a host unit, can fall in the same cycle as a pop from the codec side. The bench fills the buffer to its depth and then sends one more unit. It raises the pop exactly in the cycle in which that unit's push reaches the buffer, which is the fourth system edge after the final bit-clock rise. The push must not be dropped as a push into a full buffer, so the drained contents must be the second to fourth old words followed by the new one. The checker also requires the occupancy to stay unchanged across such a cycle.

// File: rtl/ctlport_pkg.sv
package ctlport_pkg;
   typedef enum logic [1:0] {
      XF_EXT  = 2'b00,
      XF_BUF  = 2'b01,
      XF_CFG  = 2'b10,
      XF_STAT = 2'b11
   } xfer_t;
endpackage

// File: rtl/ctlport_sync.sv
module ctlport_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stg
      if (s == 0) begin : g_first
         always_ff @(posedge clk_i or negedge rst_ni)
            if (!rst_ni) stg[s] <= '0;
            else         stg[s] <= d_i;
      end else begin : g_next
         always_ff @(posedge clk_i or negedge rst_ni)
            if (!rst_ni) stg[s] <= '0;
            else         stg[s] <= stg[s-1];
      end
   end

   assign q_o = stg[STAGES-1];
endmodule

// File: rtl/ctlport_fifo.sv
module ctlport_fifo #(
   parameter int W     = 16,
   parameter int DEPTH = 4,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          push_i,
   input  logic [W-1:0]  data_i,
   input  logic          pop_i,
   output logic [W-1:0]  data_o,
   output logic          valid_o,
   output logic          full_o,
   output logic [CW-1:0] count_o
);
   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp, wp_n, rp_n;
   logic [CW-1:0] cnt;
   logic          pop_ok, push_ok;

   assign full_o  = (cnt == CW'(DEPTH));
   assign valid_o = (cnt != '0);
   assign pop_ok  = pop_i & valid_o;
   assign push_ok = push_i & (~full_o | pop_ok);

   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wp_n = wp + 1'b1;
      assign rp_n = rp + 1'b1;
   end else begin : g_mod
      assign wp_n = (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      assign rp_n = (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
   end

   always_ff @(posedge clk_i)
      if (push_ok) mem[wp] <= data_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push_ok) wp <= wp_n;
         if (pop_ok)  rp <= rp_n;
         case ({push_ok, pop_ok})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   assign data_o  = mem[rp];
   assign count_o = cnt;
endmodule

// File: rtl/ctlport_engine.sv
module ctlport_engine import ctlport_pkg::*; #(
   parameter int BYTE_W    = 8,
   parameter int READY_BIT = 13,
   localparam int UNIT_W   = 2 * BYTE_W,
   localparam int CNT_W    = $clog2(UNIT_W)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              en_s,
   input  logic              sck_s,
   input  logic              sdi_s,
   input  logic [1:0]        sel_s,
   input  logic [UNIT_W-1:0] status_i,
   input  logic              ready_i,
   output logic [UNIT_W-1:0] word_o,
   output logic [BYTE_W-1:0] byte_o,
   output logic              ext_stb_o,
   output logic              cfg_stb_o,
   output logic              buf_stb_o,
   output logic              sdo_o,
   output logic              sdo_oe_o
);
   xfer_t             kind;
   logic              en_d, sck_d, sat;
   logic [CNT_W-1:0]  cnt;
   logic [UNIT_W-1:0] sr, snap, status_mix;
   logic              en_rise, sck_rise;

   assign en_rise  = en_s & ~en_d;
   assign sck_rise = sck_s & ~sck_d & en_s & en_d;

   always_comb begin
      status_mix            = status_i;
      status_mix[READY_BIT] = ready_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_d      <= 1'b0;
         sck_d     <= 1'b0;
         kind      <= XF_EXT;
         sat       <= 1'b0;
         cnt       <= '0;
         sr        <= '0;
         snap      <= '0;
         sdo_o     <= 1'b0;
         ext_stb_o <= 1'b0;
         cfg_stb_o <= 1'b0;
         buf_stb_o <= 1'b0;
      end else begin
         en_d      <= en_s;
         sck_d     <= sck_s;
         ext_stb_o <= 1'b0;
         cfg_stb_o <= 1'b0;
         buf_stb_o <= 1'b0;
         if (en_rise) begin
            kind  <= xfer_t'(sel_s);
            sat   <= 1'b0;
            cnt   <= '0;
            snap  <= status_mix;
            sdo_o <= 1'b0;
         end else if (sck_rise && !sat) begin
            sr  <= {sdi_s, sr[UNIT_W-1:1]};
            cnt <= cnt + 1'b1;
            case (kind)
               XF_EXT:  if (cnt == CNT_W'(BYTE_W - 1)) begin
                           ext_stb_o <= 1'b1;
                           sat       <= 1'b1;
                        end
               XF_CFG:  if (cnt == CNT_W'(UNIT_W - 1)) begin
                           cfg_stb_o <= 1'b1;
                           sat       <= 1'b1;
                        end
               XF_BUF:  if (cnt == CNT_W'(UNIT_W - 1)) buf_stb_o <= 1'b1;
               default: begin
                           sdo_o <= snap[cnt ^ CNT_W'(BYTE_W)];
                           if (cnt == CNT_W'(UNIT_W - 1)) sat <= 1'b1;
                        end
            endcase
         end
      end
   end

   // first-sent byte settles in the low half of the shifter
   assign word_o   = {sr[BYTE_W-1:0], sr[UNIT_W-1:BYTE_W]};
   assign byte_o   = sr[UNIT_W-1:BYTE_W];
   assign sdo_oe_o = en_s & en_d & (kind == XF_STAT);
endmodule

// File: rtl/ctlport_top.sv
module ctlport_top #(
   parameter int BYTE_W                  = 8,
   parameter int DEPTH                   = 4,
   parameter int SYNC                    = 2,
   parameter int READY_BIT               = 13,
   parameter logic [2*BYTE_W-1:0] CFG_RESET = '0
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  en_i,
   input  logic                  sck_i,
   input  logic [1:0]            sel_i,
   input  logic                  sdi_i,
   output logic                  sdo_o,
   output logic                  sdo_oe_o,
   input  logic [2*BYTE_W-1:0]   status_i,
   output logic [BYTE_W/2-1:0]   gpo_o,
   output logic [2*BYTE_W-1:0]   cfg_o,
   output logic [2*BYTE_W-1:0]   buf_data_o,
   output logic                  buf_valid_o,
   input  logic                  buf_pop_i
);
   localparam int UNIT_W = 2 * BYTE_W;
   localparam int NIB_W  = BYTE_W / 2;
   localparam int CW     = $clog2(DEPTH + 1);

   if (BYTE_W < 4 || (BYTE_W % 2) != 0) begin : g_bad_byte
      $error("BYTE_W must be even and at least 4");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("DEPTH must be at least 2");
   end
   if (SYNC < 2 || SYNC > 8) begin : g_bad_sync
      $error("SYNC must lie in 2..8");
   end
   if (READY_BIT >= UNIT_W) begin : g_bad_ready
      $error("READY_BIT outside the status word");
   end

   logic              en_s, sck_s, sdi_s;
   logic [1:0]        sel_s;
   logic [UNIT_W-1:0] word;
   logic [BYTE_W-1:0] ext_byte;
   logic              ext_stb, cfg_stb, buf_push, buf_full, ext_hit;
   logic [CW-1:0]     buf_count;

   ctlport_sync #(.W(5), .STAGES(SYNC)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   ({sel_i, sdi_i, sck_i, en_i}),
      .q_o   ({sel_s, sdi_s, sck_s, en_s})
   );

   ctlport_engine #(.BYTE_W(BYTE_W), .READY_BIT(READY_BIT)) u_eng (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_s     (en_s),
      .sck_s    (sck_s),
      .sdi_s    (sdi_s),
      .sel_s    (sel_s),
      .status_i (status_i),
      .ready_i  (~buf_full),
      .word_o   (word),
      .byte_o   (ext_byte),
      .ext_stb_o(ext_stb),
      .cfg_stb_o(cfg_stb),
      .buf_stb_o(buf_push),
      .sdo_o    (sdo_o),
      .sdo_oe_o (sdo_oe_o)
   );

   ctlport_fifo #(.W(UNIT_W), .DEPTH(DEPTH)) u_fifo (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .push_i (buf_push),
      .data_i (word),
      .pop_i  (buf_pop_i),
      .data_o (buf_data_o),
      .valid_o(buf_valid_o),
      .full_o (buf_full),
      .count_o(buf_count)
   );

   assign ext_hit = ext_stb & (ext_byte[BYTE_W-1:NIB_W] == '0);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         gpo_o <= '0;
         cfg_o <= CFG_RESET;
      end else begin
         if (ext_hit) gpo_o <= ext_byte[NIB_W-1:0];
         if (cfg_stb) cfg_o <= word;
      end
   end
endmodule

// File: rtl/ctlport_chk.sv
module ctlport_chk #(
   parameter int DEPTH = 4,
   parameter int SYNC  = 2,
   parameter int CW    = 3,
   parameter int NG    = 4
) (
   input logic          clk_i,
   input logic          rst_ni,
   input logic          en_i,
   input logic          oe,
   input logic [CW-1:0] count,
   input logic          full,
   input logic          push,
   input logic          pop,
   input logic [NG-1:0] gpo,
   input logic          ext_hit
);
   logic [7:0] low_cnt;

   always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)                   low_cnt <= 8'd0;
      else if (en_i)                 low_cnt <= 8'd0;
      else if (low_cnt < 8'd255)     low_cnt <= low_cnt + 8'd1;

   // R10
   oe_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (low_cnt > 8'(SYNC)) |-> !oe);

   // R8
   full_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (push && full && !pop) |=> $stable(count));

   // R11
   push_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (push && pop && count != '0) |=> $stable(count));

   // R7
   empty_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pop && count == '0 && !push) |=> (count == '0));

   // R6
   depth_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      count <= CW'(DEPTH));

   // R2
   gpo_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(gpo) |-> $past(ext_hit));
endmodule

bind ctlport_top ctlport_chk #(
   .DEPTH(DEPTH), .SYNC(SYNC), .CW($clog2(DEPTH + 1)), .NG(BYTE_W / 2)
) u_chk (
   .clk_i  (clk_i),
   .rst_ni (rst_ni),
   .en_i   (en_i),
   .oe     (sdo_oe_o),
   .count  (buf_count),
   .full   (buf_full),
   .push   (buf_push),
   .pop    (buf_pop_i),
   .gpo    (gpo_o),
   .ext_hit(ext_hit)
);

// File: tb/tb_ctlport_top.sv
`timescale 1ns/1ps
module tb_ctlport_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0, sck = 1'b0, sdi = 1'b0, pop = 1'b0;
   logic [1:0]  sel = 2'b00;
   logic [15:0] status = 16'h0000;
   logic        sdo, oe, bvalid;
   logic [3:0]  gpo;
   logic [15:0] cfg, bdata;
   int          n_chk = 0, n_bad = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   ctlport_top dut (
      .clk_i(clk), .rst_ni(rst_n), .en_i(en), .sck_i(sck), .sel_i(sel),
      .sdi_i(sdi), .sdo_o(sdo), .sdo_oe_o(oe), .status_i(status),
      .gpo_o(gpo), .cfg_o(cfg), .buf_data_o(bdata), .buf_valid_o(bvalid),
      .buf_pop_i(pop)
   );

   task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic begin_xfer(input logic [1:0] s);
      sel = s; wait_n(4); en = 1'b1; wait_n(8);
   endtask

   task automatic end_xfer();
      sck = 1'b0; en = 1'b0; wait_n(8);
   endtask

   task automatic send_bit(input logic b);
      sdi = b; sck = 1'b0; wait_n(8); sck = 1'b1; wait_n(8);
   endtask

   task automatic send_byte(input logic [7:0] b);
      for (int i = 0; i < 8; i++) send_bit(b[i]);
   endtask

   task automatic send_word(input logic [15:0] w);
      send_byte(w[15:8]); send_byte(w[7:0]);
   endtask

   task automatic read_bit(output logic b);
      sck = 1'b0; wait_n(8); sck = 1'b1; wait_n(6); b = sdo; wait_n(2);
   endtask

   task automatic read_word(output logic [15:0] w, input logic [15:0] late_status);
      logic b;
      for (int i = 0; i < 16; i++) begin
         read_bit(b);
         if (i < 8) w[8 + i] = b; else w[i - 8] = b;
         if (i == 3) status = late_status;
      end
   endtask

   task automatic pop_expect(input logic [15:0] exp, input string req);
      check(bvalid === 1'b1, req, {15'd0, bvalid}, 16'd1);
      check(bdata === exp, req, bdata, exp);
      pop = 1'b1; wait_n(1); pop = 1'b0; wait_n(1);
   endtask

   task automatic t_reset();
      check(oe === 1'b0, "R1 oe", {15'd0, oe}, 16'd0);
      check(gpo === 4'd0, "R1 gpo", {12'd0, gpo}, 16'd0);
      check(cfg === 16'h0000, "R1 cfg", cfg, 16'h0000);
      check(bvalid === 1'b0, "R1 valid", {15'd0, bvalid}, 16'd0);
   endtask

   task automatic t_ext();
      begin_xfer(2'b00); send_byte({4'h0, 4'b1011}); end_xfer();
      check(gpo === 4'b1011, "R2 gpo addr0", {12'd0, gpo}, 16'h000B);
      begin_xfer(2'b00); send_byte({4'h3, 4'b0100}); end_xfer();
      check(gpo === 4'b1011, "R3 gpo addr3", {12'd0, gpo}, 16'h000B);
   endtask

   task automatic t_cfg();
      begin_xfer(2'b10); send_word(16'hC35A); end_xfer();
      check(cfg === 16'hC35A, "R4 cfg", cfg, 16'hC35A);
   endtask

   task automatic t_partial();
      begin_xfer(2'b10); send_byte(8'h11); end_xfer();
      check(cfg === 16'hC35A, "R5 cfg partial", cfg, 16'hC35A);
      begin_xfer(2'b00); for (int i = 0; i < 5; i++) send_bit(1'b0); end_xfer();
      check(gpo === 4'b1011, "R5 gpo partial", {12'd0, gpo}, 16'h000B);
      begin_xfer(2'b01); send_byte(8'hEE); end_xfer();
      check(bvalid === 1'b0, "R5 buffer partial", {15'd0, bvalid}, 16'd0);
   endtask

   task automatic t_buf();
      begin_xfer(2'b01); send_word(16'h1234); send_word(16'hABCD); end_xfer();
      pop_expect(16'h1234, "R6 first");
      pop_expect(16'hABCD, "R6 second");
      pop = 1'b1; wait_n(1); pop = 1'b0; wait_n(1);
      check(bvalid === 1'b0, "R7 empty pop", {15'd0, bvalid}, 16'd0);
      begin_xfer(2'b01); send_word(16'h0F3C); end_xfer();
      pop_expect(16'h0F3C, "R7 after empty pop");
   endtask

   task automatic t_status();
      logic [15:0] w;
      status = 16'h5A3C;
      begin_xfer(2'b11);
      check(oe === 1'b1, "R9 oe", {15'd0, oe}, 16'd1);
      read_word(w, 16'hFFFF);
      check(w === 16'h7A3C, "R9 status word", w, 16'h7A3C);
      end_xfer();
      check(oe === 1'b0, "R10 oe release", {15'd0, oe}, 16'd0);
   endtask

   task automatic t_full();
      logic [15:0] w;
      begin_xfer(2'b01);
      send_word(16'hA001); send_word(16'hA002); send_word(16'hA003); send_word(16'hA004);
      end_xfer();
      begin_xfer(2'b01); send_word(16'hA005); end_xfer();
      status = 16'hFFFF;
      begin_xfer(2'b11); read_word(w, 16'hFFFF); end_xfer();
      check(w === 16'hDFFF, "R8 ready low", w, 16'hDFFF);
      pop_expect(16'hA001, "R8 e1"); pop_expect(16'hA002, "R8 e2");
      pop_expect(16'hA003, "R8 e3"); pop_expect(16'hA004, "R8 e4");
      check(bvalid === 1'b0, "R8 dropped", {15'd0, bvalid}, 16'd0);
   endtask

   task automatic t_pushpop();
      logic [15:0] nw;
      nw = 16'h5555;
      begin_xfer(2'b01);
      send_word(16'h1111); send_word(16'h2222); send_word(16'h3333); send_word(16'h4444);
      end_xfer();
      begin_xfer(2'b01);
      send_byte(nw[15:8]);
      for (int i = 0; i < 7; i++) send_bit(nw[i]);
      sdi = nw[7]; sck = 1'b0; wait_n(8); sck = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk); pop = 1'b1; @(negedge clk); pop = 1'b0;
      wait_n(6);
      end_xfer();
      pop_expect(16'h2222, "R11 e2"); pop_expect(16'h3333, "R11 e3");
      pop_expect(16'h4444, "R11 e4"); pop_expect(16'h5555, "R11 new");
      check(bvalid === 1'b0, "R11 empty", {15'd0, bvalid}, 16'd0);
   endtask

   initial begin
      wait_n(5); rst_n = 1'b1; wait_n(3);
      t_reset();
      t_ext();
      t_cfg();
      t_partial();
      t_buf();
      t_status();
      t_full();
      t_pushpop();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=%h expected=%h", 16'd0, 16'd1);
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule